// File: doc/BRIEF.md
# Processor status flag register

This block holds the arithmetic condition flags of a small processor core and a one-bit transfer flag. Each cycle the ALU can update any subset of five flags: carry, zero, negative, two's-complement overflow and half carry. It does this through a per-flag enable vector. Zero and negative are derived here from the presented result byte. Carry, overflow and half carry are supplied by the ALU. The sign flag is never written by the ALU. It follows the negative and overflow flags.

The transfer flag supports moving a single bit. A store operation copies one selected bit of an operand byte into the transfer flag. A combinational insert path returns the operand with the transfer flag placed at the selected bit position. A full-byte software write loads every flag at once and takes priority over all other updates in the same cycle. Bit 7 of the status byte always reads as zero.

Top module: `status_flags`

## Requirements
- R1: Asserting `rst_ni` low clears all of `status_o` to 0x00 asynchronously, without waiting for a clock edge.
- R2: When enabled, the zero flag is set to 1 exactly when `result_i` is 0x00. When enabled, the negative flag takes `result_i[7]`.
- R3: `flag_we_i` enables the flags one bit each: bit 0 carry (from `carry_i`), bit 1 zero, bit 2 negative, bit 3 overflow (from `ovf_i`), bit 4 half carry (from `half_i`). A flag whose enable bit is low keeps its value.
- R4: In any cycle where the negative or the overflow enable is high, the sign flag is set to the XOR of the new negative and overflow values. Otherwise the sign flag holds its value.
- R5: When `tstore_i` is high, the transfer flag takes `operand_i[bit_sel_i]` at the clock edge.
- R6: `ins_byte_o` equals `operand_i` with bit `bit_sel_i` replaced by the current transfer flag. This path is combinational, and the other seven bits are unchanged.
- R7: When `sw_we_i` is high, bits 6:0 of `sw_data_i` are stored as given, including the sign bit, which is not recomputed. This write overrides ALU and store updates in the same cycle.
- R8: `status_o[7]` is always 0, whatever is written through any path.
- R9: The status byte layout is: bit 0 carry, bit 1 zero, bit 2 negative, bit 3 overflow, bit 4 sign, bit 5 half carry, bit 6 transfer flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flag_we_i | input | 5 | Per-flag ALU write enables (C, Z, N, V, H from bit 0 up) |
| result_i | input | 8 | ALU result byte used for the zero and negative flags |
| carry_i | input | 1 | New carry value |
| ovf_i | input | 1 | New overflow value |
| half_i | input | 1 | New half-carry value (carry out of bit 3) |
| tstore_i | input | 1 | Copy the selected operand bit into the transfer flag |
| bit_sel_i | input | 3 | Bit index for store and insert |
| operand_i | input | 8 | Operand byte for store and insert |
| ins_byte_o | output | 8 | Operand with the transfer flag inserted at `bit_sel_i` |
| sw_we_i | input | 1 | Full-byte write strobe |
| sw_data_i | input | 8 | Full-byte write data |
| status_o | output | 8 | Status byte |

## Verification
A chain of ALU update vectors covers several cases, each starting from the state the previous vector left. It writes all flags at once, negative alone, overflow alone, no flags at all, and mixed subsets. The resulting bytes separate a wrong sign derivation from a stale one, and a missing hold from a wrong enable bit. The transfer flag is stored from a set bit and from a clear bit. It is then inserted at the top bit into a zero byte and at a middle bit into an all-ones byte, so a misplaced or inverted insert shows. Software writes of 0xFF and of 0x00, issued against a competing full ALU update and store, show that the sign bit is kept as written, that bit 7 stays zero and that the software write has priority.

// File: rtl/status_flags_pkg.sv
package status_flags_pkg;
  localparam int unsigned STATUS_W = 8;
  // status byte bit positions
  localparam int unsigned FLAG_C = 0;
  localparam int unsigned FLAG_Z = 1;
  localparam int unsigned FLAG_N = 2;
  localparam int unsigned FLAG_V = 3;
  localparam int unsigned FLAG_S = 4;
  localparam int unsigned FLAG_H = 5;
  localparam int unsigned FLAG_T = 6;
  localparam int unsigned STORED_W = STATUS_W - 1;
  // ALU enable vector positions
  localparam int unsigned WE_C = 0;
  localparam int unsigned WE_Z = 1;
  localparam int unsigned WE_N = 2;
  localparam int unsigned WE_V = 3;
  localparam int unsigned WE_H = 4;
  localparam int unsigned NUM_WE = 5;

  typedef struct packed {
    logic t;
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/flag_update.sv
module flag_update
  import status_flags_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  flags_t              cur_i,
  input  logic [NUM_WE-1:0]   we_i,
  input  logic [DATA_W-1:0]   result_i,
  input  logic                carry_i,
  input  logic                ovf_i,
  input  logic                half_i,
  output flags_t              nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (we_i[WE_C]) nxt_o.c = carry_i;
    if (we_i[WE_Z]) nxt_o.z = ~|result_i;
    if (we_i[WE_N]) nxt_o.n = result_i[DATA_W-1];
    if (we_i[WE_V]) nxt_o.v = ovf_i;
    if (we_i[WE_H]) nxt_o.h = half_i;
    // sign follows the post-update N and V
    if (we_i[WE_N] | we_i[WE_V]) nxt_o.s = nxt_o.n ^ nxt_o.v;
  end
endmodule

// File: rtl/bit_xfer.sv
module bit_xfer #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic [IDX_W-1:0]  sel_i,
  input  logic              t_i,
  output logic              bit_o,
  output logic [DATA_W-1:0] ins_o
);
  assign bit_o = operand_i[sel_i];

  for (genvar g = 0; g < DATA_W; g++) begin : g_ins
    assign ins_o[g] = (sel_i == IDX_W'(g)) ? t_i : operand_i[g];
  end
endmodule

// File: rtl/status_flags.sv
module status_flags
  import status_flags_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_WE-1:0]   flag_we_i,
  input  logic [DATA_W-1:0]   result_i,
  input  logic                carry_i,
  input  logic                ovf_i,
  input  logic                half_i,
  input  logic                tstore_i,
  input  logic [IDX_W-1:0]    bit_sel_i,
  input  logic [DATA_W-1:0]   operand_i,
  output logic [DATA_W-1:0]   ins_byte_o,
  input  logic                sw_we_i,
  input  logic [STATUS_W-1:0] sw_data_i,
  output logic [STATUS_W-1:0] status_o
);
  flags_t flags_q, flags_d, alu_nxt;
  logic   ext_bit;

  flag_update #(.DATA_W(DATA_W)) u_upd (
    .cur_i    (flags_q),
    .we_i     (flag_we_i),
    .result_i (result_i),
    .carry_i  (carry_i),
    .ovf_i    (ovf_i),
    .half_i   (half_i),
    .nxt_o    (alu_nxt)
  );

  bit_xfer #(.DATA_W(DATA_W)) u_xfer (
    .operand_i (operand_i),
    .sel_i     (bit_sel_i),
    .t_i       (flags_q.t),
    .bit_o     (ext_bit),
    .ins_o     (ins_byte_o)
  );

  // priority: software write > (ALU flags, transfer store)
  always_comb begin
    flags_d = alu_nxt;
    if (tstore_i) flags_d.t = ext_bit;
    if (sw_we_i)  flags_d = flags_t'(sw_data_i[STORED_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign status_o = {1'b0, flags_q};
endmodule

// File: rtl/status_flags_chk.sv
module status_flags_chk #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [4:0]        flag_we_i,
  input logic [DATA_W-1:0] result_i,
  input logic              carry_i,
  input logic              ovf_i,
  input logic              half_i,
  input logic              tstore_i,
  input logic [IDX_W-1:0]  bit_sel_i,
  input logic [DATA_W-1:0] operand_i,
  input logic [DATA_W-1:0] ins_byte_o,
  input logic              sw_we_i,
  input logic [7:0]        sw_data_i,
  input logic [7:0]        status_o
);
  p_bit7_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7] == 1'b0);

  p_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i[1] && !sw_we_i |=> status_o[1] == ($past(result_i) == '0));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i == 5'b0 && !sw_we_i && !tstore_i |=> $stable(status_o));

  p_sign_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i[2] || flag_we_i[3]) && !sw_we_i |=> status_o[4] == (status_o[2] ^ status_o[3]));

  p_store_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tstore_i && !sw_we_i |=> status_o[6] == $past(operand_i[bit_sel_i]));

  p_insert_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_byte_o[bit_sel_i] == status_o[6] && $countones(ins_byte_o ^ operand_i) <= 1);

  p_sw_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_we_i |=> status_o[6:0] == $past(sw_data_i[6:0]));
endmodule

bind status_flags status_flags_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/status_flags_bench.sv
module status_flags_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] flag_we_i = '0;
  logic [7:0] result_i = '0;
  logic       carry_i = 1'b0, ovf_i = 1'b0, half_i = 1'b0;
  logic       tstore_i = 1'b0;
  logic [2:0] bit_sel_i = '0;
  logic [7:0] operand_i = '0;
  logic [7:0] ins_byte_o;
  logic       sw_we_i = 1'b0;
  logic [7:0] sw_data_i = '0;
  logic [7:0] status_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  status_flags u_status_flags (.*);

  // {we[4:0] (H,V,N,Z,C), result, carry, ovf, half, expected status}
  localparam logic [23:0] VEC [8] = '{
    {5'b11111, 8'h00, 1'b1, 1'b0, 1'b1, 8'h23},
    {5'b00100, 8'h80, 1'b0, 1'b0, 1'b0, 8'h37},
    {5'b01000, 8'h00, 1'b0, 1'b1, 1'b0, 8'h2F},
    {5'b00000, 8'hFF, 1'b1, 1'b0, 1'b0, 8'h2F},
    {5'b10011, 8'h01, 1'b0, 1'b0, 1'b0, 8'h0C},
    {5'b01100, 8'h7F, 1'b0, 1'b0, 1'b0, 8'h00},
    {5'b01100, 8'h00, 1'b0, 1'b1, 1'b0, 8'h18},
    {5'b00010, 8'h00, 1'b0, 1'b0, 1'b0, 8'h1A}
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle();
    flag_we_i = '0; tstore_i = 1'b0; sw_we_i = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    check("R1 reset", status_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 R3 R4 R9: ALU update chain
    for (int i = 0; i < 8; i++) begin
      {flag_we_i, result_i, carry_i, ovf_i, half_i} = VEC[i][23:8];
      tick();
      check($sformatf("R2/R3/R4/R9 vec%0d", i), status_o, VEC[i][7:0]);
    end
    idle();

    // R5 store a set bit
    tstore_i = 1'b1; operand_i = 8'hA5; bit_sel_i = 3'd0;
    tick();
    check("R5 store one", status_o, 8'h5A);
    idle();

    // R6 insert T=1 at bit 7; R3 hold with nothing enabled
    operand_i = 8'h00; bit_sel_i = 3'd7;
    #1 check("R6 insert one", ins_byte_o, 8'h80);
    tick();
    check("R3 hold", status_o, 8'h5A);

    // R5 store a clear bit
    tstore_i = 1'b1; operand_i = 8'hA5; bit_sel_i = 3'd1;
    tick();
    check("R5 store zero", status_o, 8'h1A);
    idle();

    // R6 insert T=0 at bit 3
    operand_i = 8'hFF; bit_sel_i = 3'd3;
    #1 check("R6 insert zero", ins_byte_o, 8'hF7);

    // R7 R8 software write of all ones
    sw_we_i = 1'b1; sw_data_i = 8'hFF;
    tick();
    check("R7/R8 sw write", status_o, 8'h7F);

    // R7 priority over ALU and store
    sw_data_i = 8'h00; flag_we_i = 5'b11111; result_i = 8'h00;
    carry_i = 1'b1; half_i = 1'b1; tstore_i = 1'b1; operand_i = 8'hFF; bit_sel_i = 3'd0;
    tick();
    check("R7 priority", status_o, 8'h00);
    idle();

    // R1 asynchronous reset
    sw_we_i = 1'b1; sw_data_i = 8'h7F;
    tick();
    idle();
    #2 rst_ni = 1'b0;
    #1 check("R1 async reset", status_o, 8'h00);
    @(negedge clk_i);
    check("R1 held in reset", status_o, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule